// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the register-access front end of an eight-input interrupt controller. Software reaches it through two byte-wide locations: a command location (`addr` = 0) and a data location (`addr` = 1). Writes to the command location are sorted by their bit pattern into three kinds: an initialization start, a mode/read command, and an end-of-interrupt/priority command. Writes to the data location either feed the initialization sequence or load the mask register.

The block owns the request, in-service and mask registers and the configuration state. That state is the vector base, the automatic end-of-interrupt mode, rotation on automatic end-of-interrupt, the read selection, the special mask, a pending poll and the lowest-priority pointer. An external priority resolver looks at these registers and returns the number of the winning input on `res_num`. An `ack` pulse moves that input from the request register into the in-service register. After a poll command, the next read returns the resolver's number instead of a register. Unsupported mode settings and unknown command codes take no action and raise a sticky error flag.

Top module: `intc_cmd_port`

## Requirements
- R1: After reset the mask register reads 0xFF, the request and in-service registers are 0, the lowest-priority pointer is 7, `err` is 0, and a command-location read returns the request register.
- R2: A command write with bit 4 set clears the mask, in-service and request registers, sets the lowest-priority pointer to 7, clears auto-EOI and rotate-on-auto-EOI, and pulses `req_drop` in that same cycle.
- R3: After an initialization start, the first data write sets `vec_base` to the written value with bits 2:0 cleared. The second data write is a cascade byte with no effect. A third byte is taken only if bit 0 of the start byte was 1. Data writes outside this sequence load the mask register, and data writes inside it never do.
- R4: In the optional third data byte, bit 1 selects auto-EOI. With auto-EOI on, an acknowledge sets no in-service bit. Command 0x80 turns rotation on, and while it is on an acknowledge under auto-EOI sets the lowest-priority pointer to the acknowledged number. Command 0x00 turns rotation off.
- R5: An `ack` pulse clears request bit `res_num`, and when auto-EOI is off it sets in-service bit `res_num`.
- R6: A command write with bits 4:3 = 01 and bit 2 = 0 sets the read selection from bits 1:0: 11 selects the in-service register and 10 selects the request register for command-location reads. Other values of bits 1:0 leave the selection unchanged. Data-location reads return the mask.
- R7: In the same command kind as R6, bits 6:5 = 11 set the special mask and 10 clear it. Other values leave it unchanged.
- R8: Command 0x20 clears the first set in-service bit, searching upward from lowest priority + 1 and wrapping past 7 to 0. Command 0xA0 does the same and then advances the lowest-priority pointer by one modulo 8.
- R9: Command 0x60+n clears in-service bit n. Command 0xE0+n clears in-service bit n and sets the lowest-priority pointer to n. Command 0xC0+n sets the pointer to n.
- R10: A command write with bits 4:3 = 01 and bit 2 = 1 arms a poll. The next read of either location returns `{5'b0, res_num}`, clears the first in-service bit found by the R8 search, and disarms the poll, so the read after it returns a register again.
- R11: Command 0x40 changes no register or state.
- R12: `err` rises and stays high on any of the following: a start byte with bit 1 or bit 3 set (initialization still proceeds), a third data byte with bit 0 clear, or a command code from the R8/R9/R4/R11 group that is not listed there (ignored).
- R13: Each bit set on `req_set` sets the matching request bit. An acknowledge in the same cycle wins for its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 1 | 0 = command location, 1 = data location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| req_set | input | 8 | Per-input request set pulses |
| ack | input | 1 | Acknowledge of the resolver's winner |
| res_num | input | 3 | Winning input number from the resolver |
| irr_q | output | 8 | Request register |
| isr_q | output | 8 | In-service register |
| imr_q | output | 8 | Mask register |
| lowest_pri | output | 3 | Lowest-priority pointer |
| spec_mask | output | 1 | Special mask mode |
| vec_base | output | 8 | Vector base, bits 2:0 zero |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| req_drop | output | 1 | Pulse telling the pending-output logic to drop |
| err | output | 1 | Sticky unsupported-encoding flag |

## Verification
Most internal errors show at the register outputs on the clock edge after the write that causes them. A wrong priority pointer or in-service bit appears one cycle after a rotate or end-of-interrupt command. The initialization counter is the exception: its state is visible only indirectly. A counter that is off by one shows up as a data write landing in the mask register when it should not, or as a missing `vec_base`/`auto_eoi` update, again one cycle later. A poll flag that fails to clear is seen on the following read, which returns the resolver number instead of a register.

// File: rtl/intc_cmd_port.sv
module intc_cmd_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] req_set,
  input  logic       ack,
  input  logic [2:0] res_num,
  output logic [7:0] irr_q,
  output logic [7:0] isr_q,
  output logic [7:0] imr_q,
  output logic [2:0] lowest_pri,
  output logic       spec_mask,
  output logic [7:0] vec_base,
  output logic       auto_eoi,
  output logic       req_drop,
  output logic       err
);
  typedef enum logic [1:0] {S_RUN = 2'd0, S_VEC = 2'd1, S_CAS = 2'd2, S_MODE = 2'd3} ist_t;

  ist_t st_q;
  logic need4_q, sel_isr, poll_q, rot_q;

  function automatic logic [7:0] first_clr(input logic [7:0] v, input logic [2:0] lp);
    logic [2:0] idx;
    logic hit;
    first_clr = '0;
    hit = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      idx = lp + 3'(k);
      if (v[idx] && !hit) begin
        hit = 1'b1;
        first_clr[idx] = 1'b1;
      end
    end
  endfunction

  wire cmd_wr  = wr_en & ~addr;
  wire dat_wr  = wr_en & addr;
  wire is_init = cmd_wr & wdata[4];
  wire is_ocw3 = cmd_wr & ~wdata[4] & wdata[3];
  wire is_ocw2 = cmd_wr & ~wdata[4] & ~wdata[3];
  wire poll_rd = rd_en & poll_q;
  wire [2:0] n = wdata[2:0];

  wire op_ns    = is_ocw2 & ((wdata == 8'h20) | (wdata == 8'hA0));
  wire op_spec  = is_ocw2 & ((wdata[7:3] == 5'b01100) | (wdata[7:3] == 5'b11100));
  wire op_setlp = is_ocw2 & ((wdata[7:3] == 5'b11000) | (wdata[7:3] == 5'b11100));
  wire op_rot   = is_ocw2 & (wdata[6:0] == 7'd0);
  wire op_nop   = is_ocw2 & (wdata == 8'h40);
  wire op_bad   = is_ocw2 & ~(op_ns | op_spec | op_setlp | op_rot | op_nop);

  wire [7:0] ack_bit = ack ? (8'h01 << res_num) : 8'h00;
  wire [7:0] isr_a   = isr_q | (auto_eoi ? 8'h00 : ack_bit);
  wire [7:0] ns_mask = first_clr(isr_a, lowest_pri);

  logic [7:0] isr_d, irr_d, imr_d;
  logic [2:0] lp_d;

  always_comb begin
    if (is_init)               isr_d = 8'h00;
    else if (op_ns || poll_rd) isr_d = isr_a & ~ns_mask;
    else if (op_spec)          isr_d = isr_a & ~(8'h01 << n);
    else                       isr_d = isr_a;

    irr_d = is_init ? 8'h00 : ((irr_q | req_set) & ~ack_bit);

    if (is_init)                      imr_d = 8'h00;
    else if (dat_wr && st_q == S_RUN) imr_d = wdata;
    else                              imr_d = imr_q;

    lp_d = lowest_pri;
    if (ack && auto_eoi && rot_q) lp_d = res_num;
    if (is_init)                  lp_d = 3'd7;
    else if (op_ns && wdata[7])   lp_d = lowest_pri + 3'd1;
    else if (op_setlp)            lp_d = n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q      <= 8'h00;
      isr_q      <= 8'h00;
      imr_q      <= 8'hFF;
      lowest_pri <= 3'd7;
      spec_mask  <= 1'b0;
      vec_base   <= 8'h00;
      auto_eoi   <= 1'b0;
      rot_q      <= 1'b0;
      sel_isr    <= 1'b0;
      poll_q     <= 1'b0;
      need4_q    <= 1'b0;
      st_q       <= S_RUN;
      err        <= 1'b0;
    end else begin
      irr_q      <= irr_d;
      isr_q      <= isr_d;
      imr_q      <= imr_d;
      lowest_pri <= lp_d;

      if (poll_rd) poll_q <= 1'b0;
      if (is_ocw3) begin
        if (wdata[2]) poll_q <= 1'b1;
        else begin
          if (wdata[1]) sel_isr   <= wdata[0];
          if (wdata[6]) spec_mask <= wdata[5];
        end
      end

      if (op_rot) rot_q <= wdata[7];

      if (is_init) begin
        auto_eoi <= 1'b0;
        rot_q    <= 1'b0;
        need4_q  <= wdata[0];
        st_q     <= S_VEC;
        if (wdata[1] || wdata[3]) err <= 1'b1;
      end else if (dat_wr) begin
        case (st_q)
          S_VEC: begin
            vec_base <= {wdata[7:3], 3'b000};
            st_q     <= S_CAS;
          end
          S_CAS:  st_q <= need4_q ? S_MODE : S_RUN;
          S_MODE: begin
            auto_eoi <= wdata[1];
            if (!wdata[0]) err <= 1'b1;
            st_q <= S_RUN;
          end
          default: st_q <= S_RUN;
        endcase
      end

      if (op_bad) err <= 1'b1;
    end
  end

  assign req_drop = is_init;
  assign rdata = poll_q ? {5'b00000, res_num} : (addr ? imr_q : (sel_isr ? isr_q : irr_q));
endmodule

// File: rtl/intc_cmd_port_chk.sv
module intc_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       ack,
  input logic [2:0] res_num,
  input logic [7:0] irr_q,
  input logic [7:0] isr_q,
  input logic [7:0] imr_q,
  input logic [2:0] lowest_pri,
  input logic [7:0] vec_base,
  input logic       auto_eoi,
  input logic       err,
  input logic [1:0] st_q,
  input logic       poll_q
);
  assert_init_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (imr_q == 8'h00 && isr_q == 8'h00 && irr_q == 8'h00 &&
                                      lowest_pri == 3'd7 && !auto_eoi));

  assert_vec_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && st_q == 2'd1) |=> (vec_base == {$past(wdata[7:3]), 3'b000}));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && st_q == 2'd0) |=> (imr_q == $past(wdata)));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && st_q != 2'd0) |=> $stable(imr_q));

  assert_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && !rd_en) |=> !irr_q[$past(res_num)]);

  assert_set_lp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:6] == 2'b11 && wdata[4:3] == 2'b00) |=> (lowest_pri == $past(wdata[2:0])));

  assert_poll_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_q && !wr_en) |=> !poll_q);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind intc_cmd_port intc_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .ack(ack), .res_num(res_num), .irr_q(irr_q), .isr_q(isr_q), .imr_q(imr_q),
  .lowest_pri(lowest_pri), .vec_base(vec_base), .auto_eoi(auto_eoi), .err(err),
  .st_q(st_q), .poll_q(poll_q)
);

// File: tb/intc_cmd_port_test.sv
module intc_cmd_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, addr = 0, ack = 0;
  logic [7:0] wdata = 0, req_set = 0;
  logic [2:0] res_num = 0;
  logic [7:0] rdata, irr_q, isr_q, imr_q, vec_base;
  logic [2:0] lowest_pri;
  logic spec_mask, auto_eoi, req_drop, err;

  int checks = 0, errors = 0;
  logic [7:0] last_rd;

  logic [7:0] m_irr, m_isr, m_imr, m_base;
  logic [2:0] m_lp;
  logic m_smm, m_aeoi, m_rot, m_sel, m_poll, m_need4, m_err;
  int m_st;

  always #2 clk = ~clk;

  intc_cmd_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .req_set(req_set), .ack(ack), .res_num(res_num), .irr_q(irr_q),
    .isr_q(isr_q), .imr_q(imr_q), .lowest_pri(lowest_pri), .spec_mask(spec_mask),
    .vec_base(vec_base), .auto_eoi(auto_eoi), .req_drop(req_drop), .err(err));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] search_clr(input logic [7:0] v, input logic [2:0] lp);
    logic [2:0] p;
    p = lp;
    repeat (8) begin
      p = p + 3'd1;
      if (v[p]) return 8'h01 << p;
    end
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_base = 0; m_lp = 7;
    m_smm = 0; m_aeoi = 0; m_rot = 0; m_sel = 0; m_poll = 0; m_need4 = 0; m_err = 0; m_st = 0;
  endtask

  task automatic model_edge();
    logic [7:0] ab, ni, nr, nm;
    logic [2:0] nl;
    ab = ack ? (8'h01 << res_num) : 8'h00;
    ni = m_isr | (m_aeoi ? 8'h00 : ab);
    nr = (m_irr | req_set) & ~ab;
    nl = (ack && m_aeoi && m_rot) ? res_num : m_lp;
    nm = m_imr;
    if (rd_en && m_poll) begin ni = ni & ~search_clr(ni, m_lp); m_poll = 0; end
    if (wr_en && !addr) begin
      if (wdata[4]) begin
        nm = 0; ni = 0; nr = 0; nl = 7; m_aeoi = 0; m_rot = 0;
        m_need4 = wdata[0]; m_st = 1;
        if (wdata[1] || wdata[3]) m_err = 1;
      end else if (wdata[3]) begin
        if (wdata[2]) m_poll = 1;
        else begin
          if (wdata[1]) m_sel = wdata[0];
          if (wdata[6]) m_smm = wdata[5];
        end
      end else if (wdata == 8'h20) ni = ni & ~search_clr(ni, m_lp);
      else if (wdata == 8'hA0) begin ni = ni & ~search_clr(ni, m_lp); nl = m_lp + 3'd1; end
      else if (wdata[7:3] == 5'b01100) ni = ni & ~(8'h01 << wdata[2:0]);
      else if (wdata[7:3] == 5'b11100) begin ni = ni & ~(8'h01 << wdata[2:0]); nl = wdata[2:0]; end
      else if (wdata[7:3] == 5'b11000) nl = wdata[2:0];
      else if (wdata[6:0] == 7'd0) m_rot = wdata[7];
      else if (wdata != 8'h40) m_err = 1;
    end
    if (wr_en && addr) begin
      case (m_st)
        0: nm = wdata;
        1: begin m_base = {wdata[7:3], 3'b000}; m_st = 2; end
        2: m_st = m_need4 ? 3 : 0;
        default: begin m_aeoi = wdata[1]; if (!wdata[0]) m_err = 1; m_st = 0; end
      endcase
    end
    m_isr = ni; m_irr = nr; m_imr = nm; m_lp = nl;
  endtask

  task automatic step();
    logic [7:0] erd;
    #1;
    erd = m_poll ? {5'b0, res_num} : (addr ? m_imr : (m_sel ? m_isr : m_irr));
    last_rd = rdata;
    if (rd_en) chk("R6/R10 rdata vs model", rdata, erd);
    if (wr_en) chk("R2 req_drop vs model", {7'b0, req_drop}, {7'b0, !addr && wdata[4]});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R13/R5 irr vs model", irr_q, m_irr);
    chk("R8/R9 isr vs model", isr_q, m_isr);
    chk("R3 imr vs model", imr_q, m_imr);
    chk("R9 lowest_pri vs model", {5'b0, lowest_pri}, {5'b0, m_lp});
    chk("R7 spec_mask vs model", {7'b0, spec_mask}, {7'b0, m_smm});
    chk("R3 vec_base vs model", vec_base, m_base);
    chk("R4 auto_eoi vs model", {7'b0, auto_eoi}, {7'b0, m_aeoi});
    chk("R12 err vs model", {7'b0, err}, {7'b0, m_err});
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; step(); wr_en = 0;
  endtask
  task automatic rd(input logic a, input logic [2:0] r);
    rd_en = 1; addr = a; res_num = r; step(); rd_en = 0;
  endtask
  task automatic ackn(input logic [2:0] r);
    ack = 1; res_num = r; step(); ack = 0;
  endtask
  task automatic req(input logic [7:0] m);
    req_set = m; step(); req_set = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] s_irr, s_isr, s_imr;
    logic [2:0] s_lp;
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset imr", imr_q, 8'hFF);
    chk("R1 reset lowest_pri", {5'b0, lowest_pri}, 8'd7);
    chk("R1 reset err", {7'b0, err}, 8'd0);
    rd(0, 0);
    chk("R1 reset command read is irr", last_rd, 8'h00);

    wr(0, 8'h11);
    chk("R2 init clears mask", imr_q, 8'h00);
    chk("R2 init lowest_pri", {5'b0, lowest_pri}, 8'd7);
    wr(1, 8'h2D);
    chk("R3 vec_base low bits cleared", vec_base, 8'h28);
    wr(1, 8'h00);
    chk("R3 cascade byte leaves mask", imr_q, 8'h00);
    wr(1, 8'h03);
    chk("R4 fourth byte auto-EOI", {7'b0, auto_eoi}, 8'd1);
    wr(1, 8'h5A);
    chk("R3 mask load after sequence", imr_q, 8'h5A);

    wr(0, 8'h10); wr(1, 8'h40); wr(1, 8'h00); wr(1, 8'hF0);
    chk("R3 no fourth byte: mask loaded", imr_q, 8'hF0);
    chk("R3 no fourth byte: auto_eoi off", {7'b0, auto_eoi}, 8'd0);
    chk("R3 second vec_base", vec_base, 8'h40);

    wr(1, 8'h00);
    req(8'h24);
    chk("R13 request set", irr_q, 8'h24);
    ackn(2);
    chk("R5 ack clears request", irr_q, 8'h20);
    chk("R5 ack sets in-service", isr_q, 8'h04);
    ackn(5);
    wr(0, 8'h0B); rd(0, 0);
    chk("R6 read select in-service", last_rd, 8'h24);
    wr(0, 8'h0A); rd(0, 0);
    chk("R6 read select request", last_rd, 8'h00);
    rd(1, 0);
    chk("R6 data read returns mask", last_rd, 8'h00);

    wr(0, 8'hC3);
    chk("R9 set lowest_pri", {5'b0, lowest_pri}, 8'd3);
    wr(0, 8'h20);
    chk("R8 non-specific EOI from lp+1", isr_q, 8'h04);
    wr(0, 8'hA0);
    chk("R8 rotating EOI wraps search", isr_q, 8'h00);
    chk("R8 rotating EOI advances lp", {5'b0, lowest_pri}, 8'd4);
    wr(0, 8'hC7);
    wr(0, 8'hA0);
    chk("R8 lp wraps 7 to 0", {5'b0, lowest_pri}, 8'd0);
    wr(0, 8'hC7);
    req(8'h42); ackn(1); ackn(6);
    wr(0, 8'h20);
    chk("R8 search starts at 0 after lp 7", isr_q, 8'h40);
    wr(0, 8'hE6);
    chk("R9 specific rotate clears bit", isr_q, 8'h00);
    chk("R9 specific rotate sets lp", {5'b0, lowest_pri}, 8'd6);
    req(8'h08); ackn(3);
    wr(0, 8'h63);
    chk("R9 specific EOI", isr_q, 8'h00);

    req(8'h11); ackn(0); ackn(4);
    s_irr = irr_q; s_isr = isr_q; s_imr = imr_q; s_lp = lowest_pri;
    wr(0, 8'h40);
    chk("R11 no-op keeps isr", isr_q, s_isr);
    chk("R11 no-op keeps irr", irr_q, s_irr);
    chk("R11 no-op keeps imr", imr_q, s_imr);
    chk("R11 no-op keeps lp", {5'b0, lowest_pri}, {5'b0, s_lp});

    wr(0, 8'h0C);
    rd(1, 3'd5);
    chk("R10 poll read returns number", last_rd, 8'h05);
    chk("R10 poll read clears highest in-service", isr_q, 8'h10);
    rd(1, 3'd5);
    chk("R10 poll disarmed after one read", last_rd, 8'h00);

    wr(0, 8'h68);
    chk("R7 special mask set", {7'b0, spec_mask}, 8'd1);
    wr(0, 8'h48);
    chk("R7 special mask clear", {7'b0, spec_mask}, 8'd0);

    wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h00); wr(1, 8'h03); wr(1, 8'h00);
    wr(0, 8'h80);
    req(8'h08); ackn(3);
    chk("R4 auto-EOI ack leaves isr", isr_q, 8'h00);
    chk("R4 rotate on auto-EOI sets lp", {5'b0, lowest_pri}, 8'd3);
    wr(0, 8'h00);
    req(8'h20); ackn(5);
    chk("R4 rotate off keeps lp", {5'b0, lowest_pri}, 8'd3);

    chk("R12 err clear before bad code", {7'b0, err}, 8'd0);
    wr(0, 8'h22);
    chk("R12 bad code raises err", {7'b0, err}, 8'd1);
    chk("R12 bad code ignored", {5'b0, lowest_pri}, 8'd3);
    wr(0, 8'h1B);
    chk("R12 bad start still initializes", imr_q, 8'h00);
    wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h02);
    chk("R12 err stays high", {7'b0, err}, 8'd1);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [7:0] c;
      r = $urandom;
      req_set = (r[31:29] == 3'd0) ? r[23:16] : 8'h00;
      case (r[3:0])
        4'd0: c = 8'h20;
        4'd1: c = 8'hA0;
        4'd2: c = {5'b01100, r[6:4]};
        4'd3: c = {5'b11100, r[6:4]};
        4'd4: c = {5'b11000, r[6:4]};
        4'd5: c = {r[7], 7'd0};
        4'd6: c = {1'b0, r[6:5], 2'b01, r[9:7]};
        4'd7: c = {7'b0001000, r[4]};
        default: c = 8'h40;
      endcase
      case (r[12:10])
        3'd0, 3'd1: wr(0, c);
        3'd2: wr(1, r[27:20]);
        3'd3: rd(r[13], r[16:14]);
        3'd4, 3'd5: ackn(r[16:14]);
        default: step();
      endcase
      req_set = 0;
    end
    finish_run();
  end
endmodule